// File: doc/BRIEF.md
# Register-File Page Translation Unit

This block is a small memory-management unit for a 16-bit machine. The complete page table of the running process sits in eight on-chip entry registers. Every logical address is translated through them: the top three bits pick an entry, and the 13-bit offset inside the 8 KB page passes through unchanged. A translation is accepted in one cycle and answered on the next.

When the operating system switches process, it presents the memory address of the new process's table image. A hardware sequencer then rewrites all eight entries from consecutive memory words, one read transaction per word, over a memory port with variable latency. The translation port reports not-ready for the whole reload, so a waiting request is held. A running counter exposes the total number of cycles spent reloading, which shows the cost of each context switch.

Top module: `pgxlate_top`

## Requirements
- R1: An accepted translation (xl_req high while xl_rdy is high) drives xl_ack high in the next cycle. When the selected entry is valid, it also returns xl_paddr = {frame of entry laddr[15:13], laddr[12:0]} with xl_fault low.
- R2: A translation through an entry whose valid bit is clear drives xl_fault high and xl_paddr to zero in its response cycle.
- R3: After reset, xl_rdy is high, xl_ack is low, reload_cycles is zero and all eight entries are invalid, so every translation faults.
- R4: A context switch reads entry i, for i = 0 to 7 in ascending order, from memory word cs_base+i (modulo 2^16). Each read is one mem_rd pulse carrying mem_addr. Word bit 15 is the valid bit and bits 14:0 are the frame number.
- R5: A word is taken only when mem_vld is high while a read is outstanding. A mem_vld pulse at any other time leaves the table unchanged.
- R6: xl_rdy is low from the cycle after a context-switch request until the eighth word is written. A request held during that time is accepted afterwards and is translated with the new table.
- R7: reload_cycles rises by one for each cycle the sequencer is busy. Each word costs one issue cycle plus the cycles spent waiting for mem_vld, inclusive of the cycle in which mem_vld is seen.
- R8: A context-switch request during a reload is held. The most recent base wins, and a fresh reload from that base follows the current one with no idle cycle between them.
- R9: When xl_req and cs_req are both high in one idle cycle, the translation is accepted and uses the table as it was before the switch. The reload starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_req | input | 1 | Translation request |
| xl_laddr | input | 16 | Logical address |
| xl_rdy | output | 1 | Translation port ready (no reload running) |
| xl_ack | output | 1 | Translation response valid |
| xl_paddr | output | 28 | Physical address (zero on fault) |
| xl_fault | output | 1 | Translation hit an invalid entry |
| cs_req | input | 1 | Context-switch request, one cycle |
| cs_base | input | 16 | Memory address of the new table image |
| mem_rd | output | 1 | Memory read pulse |
| mem_addr | output | 16 | Memory read address |
| mem_vld | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| reload_cycles | output | 32 | Total cycles spent reloading since reset |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a translation and a context-switch start: the bench raises xl_req and cs_req on the same idle edge and expects the response to come from the old table, with xl_rdy falling one cycle later. The second pair is a running reload and a new switch request: a second request issued partway through the first reload must produce exactly sixteen words of busy time and leave the second image in the table. Stray mem_vld pulses while idle check that data arriving outside an outstanding read does not touch the table.

// File: rtl/pgxlate_pkg.sv
package pgxlate_pkg;
    localparam int LA_W   = 16;
    localparam int OFF_W  = 13;
    localparam int PG_W   = LA_W - OFF_W;
    localparam int N_PG   = 1 << PG_W;
    localparam int MW     = 16;
    localparam int MA_W   = 16;
    localparam int FR_W   = MW - 1;
    localparam int PA_W   = FR_W + OFF_W;
    localparam int CNT_W  = 32;

    typedef struct packed {
        logic            vld;
        logic [FR_W-1:0] frame;
    } pte_t;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;
endpackage

// File: rtl/pgxlate_table.sv
module pgxlate_table
    import pgxlate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_idx,
    input  pte_t            wr_pte,
    input  logic [PG_W-1:0] rd_idx,
    output pte_t            rd_pte
);
    pte_t tbl_d [N_PG];
    pte_t tbl_q [N_PG];

    always_comb begin
        for (int i = 0; i < N_PG; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_idx == PG_W'(i))) tbl_d[i] = wr_pte;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_PG; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) tbl_q[g] <= '0;
                else        tbl_q[g] <= tbl_d[g];
            end
        end
    endgenerate

    assign rd_pte = tbl_q[rd_idx];
endmodule

// File: rtl/pgxlate_seq.sv
module pgxlate_seq
    import pgxlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_req,
    input  logic [MA_W-1:0]  cs_base,
    input  logic             mem_vld,
    input  logic [MW-1:0]    mem_rdata,
    output logic             mem_rd,
    output logic [MA_W-1:0]  mem_addr,
    output logic             wr_en,
    output logic [PG_W-1:0]  wr_idx,
    output pte_t             wr_pte,
    output logic             busy,
    output logic [CNT_W-1:0] cyc_cnt
);
    typedef struct packed {
        seq_e             st;
        logic [PG_W-1:0]  idx;
        logic [MA_W-1:0]  base;
        logic             pend;
        logic [MA_W-1:0]  pend_base;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        mem_rd = 1'b0;
        wr_en  = 1'b0;
        if (s_q.st != S_IDLE) s_d.cnt = s_q.cnt + 1'b1;
        unique case (s_q.st)
            S_IDLE: begin
                if (cs_req) begin
                    s_d.st   = S_ISSUE;
                    s_d.base = cs_base;
                    s_d.idx  = '0;
                end
            end
            S_ISSUE: begin
                mem_rd = 1'b1;
                s_d.st = S_WAIT;
                if (cs_req) begin
                    s_d.pend      = 1'b1;
                    s_d.pend_base = cs_base;
                end
            end
            default: begin
                if (cs_req) begin
                    s_d.pend      = 1'b1;
                    s_d.pend_base = cs_base;
                end
                if (mem_vld) begin
                    wr_en = 1'b1;
                    if (s_q.idx == PG_W'(N_PG - 1)) begin
                        s_d.idx = '0;
                        if (s_q.pend || cs_req) begin
                            s_d.st   = S_ISSUE;
                            s_d.base = cs_req ? cs_base : s_q.pend_base;
                            s_d.pend = 1'b0;
                        end else begin
                            s_d.st = S_IDLE;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = S_ISSUE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st        <= S_IDLE;
            s_q.idx       <= '0;
            s_q.base      <= '0;
            s_q.pend      <= 1'b0;
            s_q.pend_base <= '0;
            s_q.cnt       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr = s_q.base + MA_W'(s_q.idx);
    assign wr_idx   = s_q.idx;
    assign wr_pte   = pte_t'(mem_rdata);
    assign busy     = (s_q.st != S_IDLE);
    assign cyc_cnt  = s_q.cnt;
endmodule

// File: rtl/pgxlate_top.sv
module pgxlate_top
    import pgxlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_req,
    input  logic [LA_W-1:0]  xl_laddr,
    output logic             xl_rdy,
    output logic             xl_ack,
    output logic [PA_W-1:0]  xl_paddr,
    output logic             xl_fault,
    input  logic             cs_req,
    input  logic [MA_W-1:0]  cs_base,
    output logic             mem_rd,
    output logic [MA_W-1:0]  mem_addr,
    input  logic             mem_vld,
    input  logic [MW-1:0]    mem_rdata,
    output logic [CNT_W-1:0] reload_cycles
);
    typedef struct packed {
        logic            ack;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t r_d, r_q;

    logic            busy;
    logic            wr_en;
    logic [PG_W-1:0] wr_idx;
    pte_t            wr_pte;
    pte_t            look;

    pgxlate_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cs_req(cs_req), .cs_base(cs_base),
        .mem_vld(mem_vld), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pte(wr_pte),
        .busy(busy), .cyc_cnt(reload_cycles)
    );

    pgxlate_table u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pte(wr_pte),
        .rd_idx(xl_laddr[LA_W-1:OFF_W]), .rd_pte(look)
    );

    assign xl_rdy = !busy;

    always_comb begin
        r_d     = '0;
        if (xl_req && xl_rdy) begin
            r_d.ack   = 1'b1;
            r_d.fault = !look.vld;
            if (look.vld) r_d.paddr = {look.frame, xl_laddr[OFF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign xl_ack   = r_q.ack;
    assign xl_fault = r_q.fault;
    assign xl_paddr = r_q.paddr;
endmodule

// File: rtl/pgxlate_chk.sv
module pgxlate_chk
    import pgxlate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xl_req,
    input logic             xl_rdy,
    input logic             xl_ack,
    input logic             xl_fault,
    input logic [PA_W-1:0]  xl_paddr,
    input logic             mem_rd,
    input logic [CNT_W-1:0] reload_cycles
);
    AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && xl_rdy) |=> xl_ack);                                    // R1
    AST_NO_ACK_UNACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req && xl_rdy) |=> !xl_ack);                                  // R6
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_ack && xl_paddr == '0));                          // R2
    AST_CNT_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_rdy |=> reload_cycles == $past(reload_cycles) + 1'b1);         // R7
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xl_rdy |=> $stable(reload_cycles));                                // R7
    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !xl_rdy);                                               // R4
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);                                               // R4
endmodule

bind pgxlate_top pgxlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_rdy(xl_rdy),
    .xl_ack(xl_ack), .xl_fault(xl_fault), .xl_paddr(xl_paddr),
    .mem_rd(mem_rd), .reload_cycles(reload_cycles)
);

// File: tb/pgxlate_tb.sv
module pgxlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_req = 1'b0;
    logic [15:0] xl_laddr = '0;
    logic        xl_rdy, xl_ack, xl_fault;
    logic [27:0] xl_paddr;
    logic        cs_req = 1'b0;
    logic [15:0] cs_base = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        mem_vld = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [31:0] reload_cycles;

    int errors = 0;
    int checks = 0;
    int lat = 2;
    int mcnt = 0;
    logic [15:0] maddr = '0;
    logic        force_vld = 1'b0;
    logic [15:0] log_addr [32];
    int nlog = 0;

    always #10 clk = ~clk;

    pgxlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_laddr(xl_laddr),
        .xl_rdy(xl_rdy), .xl_ack(xl_ack), .xl_paddr(xl_paddr), .xl_fault(xl_fault),
        .cs_req(cs_req), .cs_base(cs_base), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_vld(mem_vld), .mem_rdata(mem_rdata), .reload_cycles(reload_cycles)
    );

    function automatic logic [15:0] img(input logic [15:0] a);
        logic [15:0] f;
        f = a * 16'd7 + 16'd3;
        return {(a[2:0] != 3'd5), f[14:0]};
    endfunction

    function automatic logic [27:0] exp_pa(input logic [15:0] base, input logic [15:0] la);
        logic [15:0] w;
        w = img(base + {13'd0, la[15:13]});
        return w[15] ? {w[14:0], la[12:0]} : 28'd0;
    endfunction

    function automatic logic exp_flt(input logic [15:0] base, input logic [15:0] la);
        logic [15:0] w;
        w = img(base + {13'd0, la[15:13]});
        return !w[15];
    endfunction

    // memory model with programmable latency
    always @(posedge clk) begin
        mem_vld <= force_vld;
        if (mem_rd) begin
            mcnt  <= lat;
            maddr <= mem_addr;
            if (nlog < 32) log_addr[nlog] <= mem_addr;
            nlog  <= nlog + 1;
        end else if (mcnt != 0) begin
            mcnt <= mcnt - 1;
            if (mcnt == 1) begin
                mem_vld   <= 1'b1;
                mem_rdata <= img(maddr);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xlate(input logic [15:0] la, output logic ack, output logic [27:0] pa, output logic flt);
        @(negedge clk);
        xl_req = 1'b1; xl_laddr = la;
        @(negedge clk);
        xl_req = 1'b0;
        ack = xl_ack; pa = xl_paddr; flt = xl_fault;
    endtask

    task automatic chk_x(input string req, input logic [15:0] base, input logic [15:0] la);
        logic a, f; logic [27:0] p;
        xlate(la, a, p, f);
        chk(req, {31'd0, a}, 32'd1);
        chk(req, {4'd0, p}, {4'd0, exp_pa(base, la)});
        chk(req, {31'd0, f}, {31'd0, exp_flt(base, la)});
    endtask

    task automatic wait_rdy();
        int n = 0;
        while (!xl_rdy && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_cs(input logic [15:0] b);
        @(negedge clk);
        cs_req = 1'b1; cs_base = b;
        @(negedge clk);
        cs_req = 1'b0;
    endtask

    localparam logic [15:0] VEC [8] = '{16'h0000, 16'h1FFF, 16'h2ABC, 16'h4001,
                                        16'h7FFF, 16'hA123, 16'hC000, 16'hE555};

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none
    end

    initial begin
        logic a, f; logic [27:0] p; logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk("R3 rdy", {31'd0, xl_rdy}, 32'd1);
        chk("R3 ack", {31'd0, xl_ack}, 32'd0);
        chk("R3 cnt", reload_cycles, 32'd0);
        xlate(16'h2345, a, p, f);
        chk("R3 fault", {31'd0, f}, 32'd1);
        chk("R3 paddr", {4'd0, p}, 32'd0);

        // first reload, latency 2: R4 R6 R7
        lat = 2; nlog = 0;
        c0 = reload_cycles;
        pulse_cs(16'h0100);
        chk("R6 rdy low", {31'd0, xl_rdy}, 32'd0);
        wait_rdy();
        chk("R7 cycles", reload_cycles - c0, 32'd32);
        for (int i = 0; i < 8; i++) chk("R4 order", {16'd0, log_addr[i]}, 32'h0100 + i);

        // vector walk: R1 R2
        for (int i = 0; i < 8; i++) chk_x(exp_flt(16'h0100, VEC[i]) ? "R2" : "R1", 16'h0100, VEC[i]);

        // R5 stray valid while idle
        @(negedge clk);
        force_vld = 1'b1;
        @(negedge clk);
        force_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk_x("R5 page5", 16'h0100, 16'hA000);
        chk_x("R5 page0", 16'h0100, 16'h0042);

        // R6 held request served after reload with new table
        lat = 1;
        pulse_cs(16'h0200);
        xl_req = 1'b1; xl_laddr = 16'h6789;
        begin
            int early = 0;
            while (!xl_rdy) begin
                if (xl_ack) early++;
                @(negedge clk);
            end
            chk("R6 no early ack", early, 0);
        end
        @(negedge clk);
        xl_req = 1'b0;
        chk("R6 ack", {31'd0, xl_ack}, 32'd1);
        chk("R6 paddr", {4'd0, xl_paddr}, {4'd0, exp_pa(16'h0200, 16'h6789)});

        // R8 switch during reload
        lat = 3;
        c0 = reload_cycles;
        pulse_cs(16'h0300);
        repeat (4) @(negedge clk);
        pulse_cs(16'h0400);
        wait_rdy();
        chk("R8 cycles", reload_cycles - c0, 32'd80);
        for (int i = 0; i < 8; i++) chk_x("R8", 16'h0400, {i[2:0], 13'h0ABC});

        // R9 same-cycle translate and switch
        @(negedge clk);
        xl_req = 1'b1; xl_laddr = 16'h2222; cs_req = 1'b1; cs_base = 16'h0500;
        @(negedge clk);
        xl_req = 1'b0; cs_req = 1'b0;
        chk("R9 ack", {31'd0, xl_ack}, 32'd1);
        chk("R9 old table", {4'd0, xl_paddr}, {4'd0, exp_pa(16'h0400, 16'h2222)});
        chk("R9 rdy low", {31'd0, xl_rdy}, 32'd0);
        wait_rdy();
        chk_x("R9 new table", 16'h0500, 16'h2222);

        // R4 base wraps past the top of memory
        lat = 1; nlog = 0;
        pulse_cs(16'hFFFC);
        wait_rdy();
        for (int i = 0; i < 8; i++) chk("R4 wrap addr", {16'd0, log_addr[i]}, {16'd0, 16'(16'hFFFC + i)});
        for (int i = 0; i < 8; i++) chk_x("R4 wrap", 16'hFFFC, {i[2:0], 13'h1001});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule